// File: doc/BRIEF.md
# Output Fault and Power-Good Supervisor

This block sits in the digital core of a synchronous buck controller. It watches the window-comparator flags taken from the feedback voltage, along with the soft-start, supply-lockout and enable conditions, and turns them into fault actions and a power-good indication. A sustained overvoltage clamps the output: the low-side switch is latched on and the controller stays off. A sustained undervoltage, checked only after soft-start has finished, puts the drivers in high impedance and also keeps the controller off. A latched fault is removed only by asserting the supply lockout or by pulling the enable input low.

Each comparator path is qualified by a delay of about 5 µs. This delay is counted in clock cycles and is derived from the clock frequency parameter. A condition must hold on every cycle of the window, or the count starts again. When the negative over-current flag is raised, the block runs a retry train. It first inhibits the low-side switch for about 2.5 µs. It then requests a short low-side pulse of about 300 ns so the current can be sensed again. The train repeats for as long as the flag stays high.

Top module: `faultSupervisor`

## Requirements
- R1: With the default 10 MHz clock the qualification window is 50 cycles. When the overvoltage flag is sampled high on 50 consecutive clock edges, forceLowOn and latchedOff become 1 and tristateDrv stays 0, starting right after the 50th edge and not before.
- R2: When the undervoltage flag is sampled high on 50 consecutive edges while ssDone is 1, tristateDrv and latchedOff become 1 and forceLowOn stays 0, starting right after the 50th edge.
- R3: A run of a comparator flag that is shorter than the window (49 edges) has no effect on any output, because the count starts again whenever the flag is low.
- R4: The undervoltage flag is ignored while ssDone is 0, for any length of time.
- R5: powerGood is 0 while ssDone is 0. After ssDone is 1 and both the overvoltage flag and the window-low flag are low for 50 consecutive edges, powerGood rises. After either flag is high for 50 consecutive edges, it falls. Shorter excursions do not change it. When ssDone drops, powerGood falls on the next edge.
- R6: A latched fault holds until supplyLockout is 1 or enableIn is 0. While either is true, tristateDrv is 1, every other output is 0 and all comparator flags are ignored. When both are released, the outputs read all 0 after the next edge.
- R7: A negative over-current flag sampled high while idle sets lowSideInhibit for 25 cycles, then senseReq for 3 cycles. At the end of the pulse the flag is sampled again: if it is high the train repeats, otherwise both outputs return to 0.
- R8: A latched fault aborts the retry train, so senseReq and lowSideInhibit go to 0. It also forces powerGood to 0. If overvoltage and undervoltage qualify on the same edge, the overvoltage action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| supplyLockout | input | 1 | 1 while the supply is below its lockout level; clears latched faults |
| enableIn | input | 1 | 1 to run the converter; 0 clears latched faults |
| ssDone | input | 1 | Soft-start sequence finished |
| ovFlag | input | 1 | Feedback above the set point by more than 10% |
| pgLowFlag | input | 1 | Feedback below the set point by more than 10% |
| uvFlag | input | 1 | Feedback below the set point by more than 30% |
| negOcFlag | input | 1 | Negative inductor current beyond its limit |
| forceLowOn | output | 1 | Hold the low-side switch on (overvoltage clamp) |
| tristateDrv | output | 1 | Put both gate drivers in high impedance |
| latchedOff | output | 1 | A fault latch is set |
| powerGood | output | 1 | Output within its window after soft-start |
| senseReq | output | 1 | Low-side re-sense pulse request |
| lowSideInhibit | output | 1 | Low-side switch held off during the retry wait |

## Verification
Every result is registered. An input changed between two edges is first sampled at the next edge. A fault latch or a power-good change therefore appears right after the 50th qualifying edge. A retry-train phase change appears right after the edge that ends the previous phase, 25 or 3 edges later. A lockout or enable change is visible after a single edge. The driver pushes each expectation with the exact cycle it is due, including the cycle one before a latch to show it is not early. The monitor compares a quarter period after each rising edge, so the negedge input changes never race the sampling.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;       // lockout or disable: restart every counter
    logic ovWatch;     // overvoltage qualification allowed
    logic uvArm;       // undervoltage qualification allowed (after soft-start)
    logic pgMismatch;  // power-good target differs from present value
    logic negRun;      // retry timer running
    logic negSense;    // timer measures the sense pulse, not the wait
  } ctrlStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic ovHit;
    logic uvHit;
    logic pgHit;
    logic negDone;
  } dpEvent_t;

  typedef enum logic [1:0] {
    NEG_IDLE  = 2'd0,
    NEG_HOLD  = 2'd1,
    NEG_SENSE = 2'd2
  } negState_t;

  localparam int NUM_QUAL = 3;
  localparam int Q_OV = 0;
  localparam int Q_UV = 1;
  localparam int Q_PG = 2;

endpackage

// File: rtl/qualTimer.sv
`timescale 1ns/1ps
// Consecutive-cycle qualifier: hit pulses on the LIMIT-th edge in a row with cond high.
module qualTimer #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic clear,
  input  logic cond,
  output logic hit
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = cond && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clear || !cond || hit) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/faultDatapath.sv
`timescale 1ns/1ps
module faultDatapath
  import supv_pkg::*;
#(
  parameter int QUAL_CYC  = 50,
  parameter int OFF_CYC   = 25,
  parameter int SENSE_CYC = 3
) (
  input  logic        clk,
  input  logic        ovFlag,
  input  logic        uvFlag,
  input  ctrlStrobe_t ctl,
  output dpEvent_t    ev
);
  localparam int NEG_MAX = (OFF_CYC > SENSE_CYC) ? OFF_CYC : SENSE_CYC;
  localparam int NW = (NEG_MAX < 2) ? 1 : $clog2(NEG_MAX);
  localparam logic [NW-1:0] OFF_LAST   = NW'(OFF_CYC - 1);
  localparam logic [NW-1:0] SENSE_LAST = NW'(SENSE_CYC - 1);

  logic [NUM_QUAL-1:0] qCond;
  logic [NUM_QUAL-1:0] qHit;

  assign qCond[Q_OV] = ovFlag && ctl.ovWatch;
  assign qCond[Q_UV] = uvFlag && ctl.uvArm;
  assign qCond[Q_PG] = ctl.pgMismatch;

  for (genvar i = 0; i < NUM_QUAL; i++) begin : g_qual
    qualTimer #(.LIMIT(QUAL_CYC)) u_qual (
      .clk  (clk),
      .clear(ctl.clear),
      .cond (qCond[i]),
      .hit  (qHit[i])
    );
  end

  // retry timer: counts cycles of the current phase
  logic [NW-1:0] negCnt;
  logic [NW-1:0] negLast;

  assign negLast = ctl.negSense ? SENSE_LAST : OFF_LAST;

  always_ff @(posedge clk) begin
    if (ctl.clear || !ctl.negRun || ev.negDone) negCnt <= '0;
    else                                        negCnt <= negCnt + 1'b1;
  end

  assign ev.ovHit   = qHit[Q_OV];
  assign ev.uvHit   = qHit[Q_UV];
  assign ev.pgHit   = qHit[Q_PG];
  assign ev.negDone = ctl.negRun && (negCnt == negLast);
endmodule

// File: rtl/faultControl.sv
`timescale 1ns/1ps
module faultControl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        supplyLockout,
  input  logic        enableIn,
  input  logic        ssDone,
  input  logic        ovFlag,
  input  logic        pgLowFlag,
  input  logic        negOcFlag,
  input  dpEvent_t    ev,
  output ctrlStrobe_t ctl,
  output logic        forceLowOn,
  output logic        tristateDrv,
  output logic        latchedOff,
  output logic        powerGood,
  output logic        senseReq,
  output logic        lowSideInhibit
);
  logic      clearNow;
  logic      ovLatched;
  logic      uvLatched;
  logic      anyLatch;
  logic      newLatch;
  logic      pgReg;
  logic      pgTarget;
  negState_t negState;
  negState_t negNext;

  assign clearNow = supplyLockout || !enableIn;
  assign anyLatch = ovLatched || uvLatched;
  assign newLatch = ev.ovHit || ev.uvHit;
  assign pgTarget = !(ovFlag || pgLowFlag);

  always_comb begin
    ctl.clear      = clearNow;
    ctl.ovWatch    = !clearNow && !anyLatch;
    ctl.uvArm      = !clearNow && !anyLatch && ssDone;
    ctl.pgMismatch = !clearNow && !anyLatch && ssDone && (pgTarget != pgReg);
    ctl.negRun     = (negState != NEG_IDLE) && !anyLatch && !clearNow;
    ctl.negSense   = (negState == NEG_SENSE);
  end

  // retry train sequencing
  always_comb begin
    negNext = negState;
    unique case (negState)
      NEG_IDLE:  if (negOcFlag)  negNext = NEG_HOLD;
      NEG_HOLD:  if (ev.negDone) negNext = NEG_SENSE;
      NEG_SENSE: if (ev.negDone) negNext = negOcFlag ? NEG_HOLD : NEG_IDLE;
      default:                   negNext = NEG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clearNow) begin
      ovLatched <= 1'b0;
      uvLatched <= 1'b0;
      pgReg     <= 1'b0;
      negState  <= NEG_IDLE;
    end else begin
      // overvoltage has priority when both qualify together
      if (!anyLatch) begin
        if (ev.ovHit)      ovLatched <= 1'b1;
        else if (ev.uvHit) uvLatched <= 1'b1;
      end

      if (anyLatch || newLatch || !ssDone) pgReg <= 1'b0;
      else if (ev.pgHit)                   pgReg <= pgTarget;

      if (anyLatch || newLatch) negState <= NEG_IDLE;
      else                      negState <= negNext;
    end
  end

  assign forceLowOn     = ovLatched && !clearNow;
  assign tristateDrv    = clearNow || uvLatched;
  assign latchedOff     = anyLatch;
  assign powerGood      = pgReg;
  assign senseReq       = (negState == NEG_SENSE);
  assign lowSideInhibit = (negState == NEG_HOLD);
endmodule

// File: rtl/faultSupervisor.sv
`timescale 1ns/1ps
module faultSupervisor
  import supv_pkg::*;
#(
  parameter int CLK_KHZ    = 10000,
  parameter int QUAL_NS    = 5000,
  parameter int NEG_OFF_NS = 2500,
  parameter int SENSE_NS   = 300
) (
  input  logic clk,
  input  logic supplyLockout,
  input  logic enableIn,
  input  logic ssDone,
  input  logic ovFlag,
  input  logic pgLowFlag,
  input  logic uvFlag,
  input  logic negOcFlag,
  output logic forceLowOn,
  output logic tristateDrv,
  output logic latchedOff,
  output logic powerGood,
  output logic senseReq,
  output logic lowSideInhibit
);
  localparam longint QUAL_RAW  = (longint'(CLK_KHZ) * QUAL_NS) / 1000000;
  localparam longint OFF_RAW   = (longint'(CLK_KHZ) * NEG_OFF_NS) / 1000000;
  localparam longint SENSE_RAW = (longint'(CLK_KHZ) * SENSE_NS) / 1000000;
  localparam int QUAL_CYC  = (QUAL_RAW  < 1) ? 1 : int'(QUAL_RAW);
  localparam int OFF_CYC   = (OFF_RAW   < 1) ? 1 : int'(OFF_RAW);
  localparam int SENSE_CYC = (SENSE_RAW < 1) ? 1 : int'(SENSE_RAW);

  ctrlStrobe_t ctl;
  dpEvent_t    ev;

  faultDatapath #(
    .QUAL_CYC (QUAL_CYC),
    .OFF_CYC  (OFF_CYC),
    .SENSE_CYC(SENSE_CYC)
  ) u_dp (
    .clk   (clk),
    .ovFlag(ovFlag),
    .uvFlag(uvFlag),
    .ctl   (ctl),
    .ev    (ev)
  );

  faultControl u_ctl (
    .clk           (clk),
    .supplyLockout (supplyLockout),
    .enableIn      (enableIn),
    .ssDone        (ssDone),
    .ovFlag        (ovFlag),
    .pgLowFlag     (pgLowFlag),
    .negOcFlag     (negOcFlag),
    .ev            (ev),
    .ctl           (ctl),
    .forceLowOn    (forceLowOn),
    .tristateDrv   (tristateDrv),
    .latchedOff    (latchedOff),
    .powerGood     (powerGood),
    .senseReq      (senseReq),
    .lowSideInhibit(lowSideInhibit)
  );
endmodule

// File: rtl/supvChecker.sv
`timescale 1ns/1ps
module supvChecker (
  input logic clk,
  input logic supplyLockout,
  input logic enableIn,
  input logic ssDone,
  input logic forceLowOn,
  input logic tristateDrv,
  input logic latchedOff,
  input logic powerGood,
  input logic senseReq,
  input logic lowSideInhibit
);
  logic held;
  assign held = supplyLockout || !enableIn;

  p_ov_drive_r1: assert property (@(posedge clk) disable iff (held)
    forceLowOn |-> (latchedOff && !tristateDrv));

  p_uv_drive_r2: assert property (@(posedge clk) disable iff (held)
    (latchedOff && !forceLowOn) |-> tristateDrv);

  p_uv_mask_r4: assert property (@(posedge clk) disable iff (held)
    ($rose(latchedOff) && !forceLowOn) |-> $past(ssDone));

  p_pg_gate_r5: assert property (@(posedge clk) disable iff (held)
    powerGood |-> $past(ssDone));

  p_sticky_r6: assert property (@(posedge clk) disable iff (held)
    latchedOff |=> latchedOff);

  p_neg_onehot_r7: assert property (@(posedge clk) disable iff (held)
    $onehot0({senseReq, lowSideInhibit, latchedOff}));

  p_pg_fault_r8: assert property (@(posedge clk) disable iff (held)
    latchedOff |-> !powerGood);
endmodule

bind faultSupervisor supvChecker u_chk (
  .clk           (clk),
  .supplyLockout (supplyLockout),
  .enableIn      (enableIn),
  .ssDone        (ssDone),
  .forceLowOn    (forceLowOn),
  .tristateDrv   (tristateDrv),
  .latchedOff    (latchedOff),
  .powerGood     (powerGood),
  .senseReq      (senseReq),
  .lowSideInhibit(lowSideInhibit)
);

// File: tb/faultSupervisor_bench.sv
`timescale 1ns/1ps
module faultSupervisor_bench;
  localparam int CLK_PERIOD = 100;     // 10 MHz
  localparam int Q = 50;               // 5 us window
  localparam int O = 25;               // 2.5 us wait
  localparam int S = 3;                // 300 ns pulse

  logic clk = 1'b0;
  logic supplyLockout = 1'b1;
  logic enableIn = 1'b0;
  logic ssDone = 1'b0;
  logic ovFlag = 1'b0;
  logic pgLowFlag = 1'b0;
  logic uvFlag = 1'b0;
  logic negOcFlag = 1'b0;
  logic forceLowOn, tristateDrv, latchedOff, powerGood, senseReq, lowSideInhibit;

  faultSupervisor u_faultSupervisor (
    .clk(clk), .supplyLockout(supplyLockout), .enableIn(enableIn), .ssDone(ssDone),
    .ovFlag(ovFlag), .pgLowFlag(pgLowFlag), .uvFlag(uvFlag), .negOcFlag(negOcFlag),
    .forceLowOn(forceLowOn), .tristateDrv(tristateDrv), .latchedOff(latchedOff),
    .powerGood(powerGood), .senseReq(senseReq), .lowSideInhibit(lowSideInhibit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    logic [5:0] vec;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // vec = {forceLowOn, tristateDrv, latchedOff, powerGood, senseReq, lowSideInhibit}
  task automatic expectAt(input int k, input logic [5:0] v, input string tag);
    item_t it;
    it.due = cyc + k;
    it.vec = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #(CLK_PERIOD/4);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [5:0] obs;
        it = q.pop_front();
        obs = {forceLowOn, tristateDrv, latchedOff, powerGood, senseReq, lowSideInhibit};
        nCmp++;
        if (it.due != cyc || obs !== it.vec) begin
          nBad++;
          $display("FAIL %s cycle %0d: actual %b expected %b", it.tag, cyc, obs, it.vec);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    waitC(3);
    expectAt(1, 6'b010000, "R6 held state");
    waitC(2);
    ovFlag = 1'b1;
    expectAt(60, 6'b010000, "R6 ov ignored during lockout");
    waitC(61);
    ovFlag = 1'b0;

    supplyLockout = 1'b0; enableIn = 1'b1;
    expectAt(1, 6'b000000, "R6 release");
    waitC(2);

    uvFlag = 1'b1;
    expectAt(60, 6'b000000, "R4 uv masked before soft-start");
    waitC(61);
    uvFlag = 1'b0;
    waitC(1);

    ssDone = 1'b1;
    expectAt(Q-1, 6'b000000, "R5 pg not early");
    expectAt(Q, 6'b000100, "R5 pg rises");
    waitC(Q+2);

    pgLowFlag = 1'b1;
    waitC(20);
    pgLowFlag = 1'b0;
    expectAt(30, 6'b000100, "R5 short dip ignored");
    waitC(31);

    pgLowFlag = 1'b1;
    expectAt(Q-1, 6'b000100, "R5 pg holds inside window");
    expectAt(Q, 6'b000000, "R5 pg falls");
    waitC(Q+1);
    pgLowFlag = 1'b0;
    expectAt(Q, 6'b000100, "R5 pg returns");
    waitC(Q+1);

    ssDone = 1'b0;
    expectAt(1, 6'b000000, "R5 pg drops with soft-start flag");
    waitC(1);
    ssDone = 1'b1;
    expectAt(Q, 6'b000100, "R5 pg back");
    waitC(Q+2);

    ovFlag = 1'b1;
    waitC(Q-1);
    ovFlag = 1'b0;
    expectAt(10, 6'b000100, "R3 short ov rejected");
    waitC(11);
    uvFlag = 1'b1;
    waitC(Q-1);
    uvFlag = 1'b0;
    expectAt(10, 6'b000100, "R3 short uv rejected");
    waitC(11);

    negOcFlag = 1'b1;
    expectAt(1, 6'b000101, "R7 wait starts");
    expectAt(O, 6'b000101, "R7 wait last cycle");
    expectAt(O+1, 6'b000110, "R7 sense pulse");
    expectAt(O+S, 6'b000110, "R7 sense last cycle");
    expectAt(O+S+1, 6'b000101, "R7 train repeats");
    waitC(O+S+2);
    negOcFlag = 1'b0;
    expectAt(O-2, 6'b000101, "R7 second wait");
    expectAt(O-1, 6'b000110, "R7 second sense");
    expectAt(O+S-1, 6'b000100, "R7 idle after flag clears");
    waitC(O+S);

    ovFlag = 1'b1; negOcFlag = 1'b1;
    expectAt(1, 6'b000101, "R7 wait under ov");
    expectAt(Q, 6'b101000, "R1 ov latch aborts train R8");
    waitC(Q+1);
    ovFlag = 1'b0; negOcFlag = 1'b0;
    expectAt(30, 6'b101000, "R6 ov latch sticky");
    waitC(31);

    enableIn = 1'b0;
    expectAt(1, 6'b010000, "R6 enable low clears");
    waitC(1);
    enableIn = 1'b1;
    expectAt(1, 6'b000000, "R6 re-enabled");
    waitC(1);

    uvFlag = 1'b1; pgLowFlag = 1'b1;
    expectAt(Q-1, 6'b000000, "R2 uv not early");
    expectAt(Q, 6'b011000, "R2 uv latch");
    waitC(Q+1);
    uvFlag = 1'b0; pgLowFlag = 1'b0;
    expectAt(10, 6'b011000, "R6 uv latch sticky");
    waitC(11);

    supplyLockout = 1'b1;
    expectAt(1, 6'b010000, "R6 lockout clears");
    waitC(1);
    supplyLockout = 1'b0;
    expectAt(1, 6'b000000, "R6 lockout released");
    waitC(1);

    ovFlag = 1'b1; uvFlag = 1'b1; pgLowFlag = 1'b1;
    expectAt(Q-1, 6'b000000, "R1 not before window");
    expectAt(Q, 6'b101000, "R8 ov beats uv");
    waitC(Q+1);
    ovFlag = 1'b0; uvFlag = 1'b0; pgLowFlag = 1'b0;

    while (q.size() > 0) waitC(1);
    waitC(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule